// File: doc/BRIEF.md
# Byte-to-Word Register Bridge

This block gives an 8-bit host indirect access to the 16-bit internal registers of a network controller. The host fills a two-byte write holding word, picks the target (register-address port or register-data port) and the direction in a control byte, and then writes anything to a command location. The bridge then runs one full 16-bit transfer on the controller side: it raises a strobe and holds it until the controller acknowledges. On a read transfer the returned word lands in a separate two-byte read holding word, which the host then fetches byte by byte.

The same control byte also drives the active-low reset line of the controller, and the status view of that byte shows whether a transfer is still running and whether the controller has an interrupt pending. If the controller never acknowledges, a timeout ends the transfer so that the host is never stuck on the busy flag.

Top module: `bb_bridge`

## Requirements
- R1: After reset the control byte is 0x00 (so `ctl_rst_n` is 0), no transfer is running (`ctl_strobe` 0, status bit 5 is 0) and both read holding bytes read 0x00.
- R2: Host offset 0 is the low byte and offset 1 the high byte. A write to them loads the write holding word; a read from them returns the read holding word, never the value written. Offset 3 reads as 0x00.
- R3: Offset 2 is the control/status byte. Bits 0, 1 and 3 read back as written; bit 4 and bit 5 are status and ignore writes; bits 2, 6 and 7 read 0.
- R4: `ctl_rst_n` follows control bit 3 (0 holds the controller in reset, 1 is normal running).
- R5: Status bit 4 reads 0 while `ctl_irq` is 1 (interrupt pending) and 1 while it is 0.
- R6: A write of any value to offset 3 while idle starts a transfer: from the next cycle `ctl_strobe` and status bit 5 are 1, `ctl_addr_sel` equals control bit 0 (1 = address port, 0 = data port), `ctl_rd` equals control bit 1 (1 = read, 0 = write), and `ctl_wdata` equals the write holding word (high byte in bits 15:8).
- R7: The strobe stays high until a cycle with `ctl_ack` 1; in that cycle a read transfer captures `ctl_rdata` into the read holding word, and from the next cycle strobe and busy are 0.
- R8: A write transfer leaves the read holding word unchanged.
- R9: A command write that arrives while a transfer is running is ignored: target, direction and the timeout window are not restarted.
- R10: With no acknowledge, the strobe stays high for exactly TIMEOUT cycles, then the transfer ends with busy cleared and the read holding word unchanged.
- R11: Target and direction are sampled at the start of a transfer; changing the control byte during the transfer does not change `ctl_addr_sel` or `ctl_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 2 | Host byte offset (0 low, 1 high, 2 control/status, 3 command) |
| hst_we | input | 1 | Host write enable |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte for the selected offset |
| ctl_rst_n | output | 1 | Active-low reset to the controller |
| ctl_addr_sel | output | 1 | 1 = register-address port, 0 = register-data port |
| ctl_rd | output | 1 | 1 = read from controller, 0 = write to it |
| ctl_strobe | output | 1 | Transfer strobe, held until acknowledge or timeout |
| ctl_wdata | output | 16 | Word written to the controller |
| ctl_rdata | input | 16 | Word returned by the controller |
| ctl_ack | input | 1 | Controller acknowledge |
| ctl_irq | input | 1 | Controller interrupt pending, active high |

## Verification
The transfer function is driven from a table that mixes read and write transfers to both the address port and the data port, with a range of acknowledge delays and with word values whose bytes differ, so that a byte swap, a wrong direction bit, a stale read word or an early strobe drop each produce a distinct mismatch. Write transfers placed after read transfers show whether the read holding word is wrongly overwritten. Directed cases then cover the reset view, read-only status bits, the interrupt polarity, a command issued mid-transfer together with a control change, and a transfer that never gets an acknowledge, where the strobe length is counted cycle by cycle.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] OFS_LO   = 2'd0;
  localparam logic [SEL_W-1:0] OFS_HI   = 2'd1;
  localparam logic [SEL_W-1:0] OFS_CTRL = 2'd2;
  localparam logic [SEL_W-1:0] OFS_CMD  = 2'd3;

  localparam int unsigned BIT_TGT  = 0;
  localparam int unsigned BIT_DIR  = 1;
  localparam int unsigned BIT_RST  = 3;
  localparam int unsigned BIT_IRQN = 4;
  localparam int unsigned BIT_BUSY = 5;

  localparam logic [7:0] CTRL_WMASK = 8'h0B;

  // Keep only the host-writable control bits.
  function automatic logic [7:0] ctrl_filter(input logic [7:0] wr);
    return wr & CTRL_WMASK;
  endfunction

  // Compose the control/status byte seen by the host.
  function automatic logic [7:0] status_view(input logic [7:0] ctrl,
                                             input logic busy,
                                             input logic irq);
    logic [7:0] s;
    s = ctrl & CTRL_WMASK;
    s[BIT_IRQN] = ~irq;
    s[BIT_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/bb_host_regs.sv
module bb_host_regs
  import bb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] hst_sel,
  input  logic             hst_we,
  input  logic [7:0]       hst_wdata,
  output logic [15:0]      wr_word,
  output logic [7:0]       ctrl_byte,
  output logic             cmd_req
);
  logic [7:0] lo_q, hi_q, ctrl_q;
  logic       wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = hst_we && (hst_sel == OFS_LO);
  assign wr_hi   = hst_we && (hst_sel == OFS_HI);
  assign wr_ctrl = hst_we && (hst_sel == OFS_CTRL);
  assign cmd_req = hst_we && (hst_sel == OFS_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= 8'h00;
      hi_q   <= 8'h00;
      ctrl_q <= 8'h00;
    end else begin
      if (wr_lo)   lo_q   <= hst_wdata;
      if (wr_hi)   hi_q   <= hst_wdata;
      if (wr_ctrl) ctrl_q <= ctrl_filter(hst_wdata);
    end
  end

  assign wr_word   = {hi_q, lo_q};
  assign ctrl_byte = ctrl_q;

  // R3: read-only and unused bits never become set
  p_ctrl_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_WMASK) == 8'h00);
  // R2: write holding word changes only by a host byte write
  p_wword_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(wr_word));
endmodule

// File: rtl/bb_xfer_fsm.sv
module bb_xfer_fsm #(
  parameter int unsigned TIMEOUT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_req,
  input  logic        tgt_in,
  input  logic        dir_in,
  input  logic        ctl_ack,
  input  logic [15:0] ctl_rdata,
  output logic        busy,
  output logic        tgt_q,
  output logic        dir_q,
  output logic [15:0] rd_word,
  output logic        cmd_fire,
  output logic        done_ack,
  output logic        done_tmo
);
  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TIMEOUT - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      rd_q;

  assign cmd_fire = cmd_req && !busy_q;
  assign done_ack = busy_q && ctl_ack;
  assign done_tmo = busy_q && !ctl_ack && (cnt_q == CNT_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= 1'b0;
      dir_q  <= 1'b0;
      rd_q   <= 16'h0000;
    end else if (cmd_fire) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      tgt_q  <= tgt_in;
      dir_q  <= dir_in;
    end else if (busy_q) begin
      if (done_ack) begin
        busy_q <= 1'b0;
        if (dir_q) rd_q <= ctl_rdata;
      end else if (done_tmo) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign rd_word = rd_q;

  // R6: a transfer begins only from an accepted command
  p_start_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_req));
  // R7: an acknowledged transfer ends in the next cycle
  p_ack_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |=> !busy_q);
  // R10: the window counter never passes its limit
  p_cnt_lim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LIM);
  // R9, R11: target and direction stay fixed during a transfer
  p_attr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !$rose(busy_q) |-> $stable(tgt_q) && $stable(dir_q));
  // R8: the read word changes only on an acknowledged read
  p_rword_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ack && dir_q) |=> $stable(rd_q));
endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int unsigned TIMEOUT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  hst_sel,
  input  logic        hst_we,
  input  logic [7:0]  hst_wdata,
  output logic [7:0]  hst_rdata,
  output logic        ctl_rst_n,
  output logic        ctl_addr_sel,
  output logic        ctl_rd,
  output logic        ctl_strobe,
  output logic [15:0] ctl_wdata,
  input  logic [15:0] ctl_rdata,
  input  logic        ctl_ack,
  input  logic        ctl_irq
);
  logic [15:0] wr_word, rd_word;
  logic [7:0]  ctrl_byte;
  logic        cmd_req, busy, tgt_q, dir_q;
  logic        cmd_fire, done_ack, done_tmo;

  bb_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_sel   (hst_sel),
    .hst_we    (hst_we),
    .hst_wdata (hst_wdata),
    .wr_word   (wr_word),
    .ctrl_byte (ctrl_byte),
    .cmd_req   (cmd_req)
  );

  bb_xfer_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req   (cmd_req),
    .tgt_in    (ctrl_byte[BIT_TGT]),
    .dir_in    (ctrl_byte[BIT_DIR]),
    .ctl_ack   (ctl_ack),
    .ctl_rdata (ctl_rdata),
    .busy      (busy),
    .tgt_q     (tgt_q),
    .dir_q     (dir_q),
    .rd_word   (rd_word),
    .cmd_fire  (cmd_fire),
    .done_ack  (done_ack),
    .done_tmo  (done_tmo)
  );

  always_comb begin
    unique case (hst_sel)
      OFS_LO:   hst_rdata = rd_word[7:0];
      OFS_HI:   hst_rdata = rd_word[15:8];
      OFS_CTRL: hst_rdata = status_view(ctrl_byte, busy, ctl_irq);
      default:  hst_rdata = 8'h00;
    endcase
  end

  assign ctl_rst_n    = ctrl_byte[BIT_RST];
  assign ctl_addr_sel = tgt_q;
  assign ctl_rd       = dir_q;
  assign ctl_strobe   = busy;
  assign ctl_wdata    = wr_word;

  // R7, R10: a transfer ends only by acknowledge or timeout
  p_end_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_strobe) |-> $past(done_ack || done_tmo));
  // R9: a command during a transfer is never accepted
  p_cmd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_strobe |-> !cmd_fire);
endmodule

// File: tb/bb_bridge_tb_top.sv
module bb_bridge_tb_top;
  localparam int unsigned TMO = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hst_sel = 2'd0;
  logic        hst_we = 1'b0;
  logic [7:0]  hst_wdata = 8'h00;
  logic [7:0]  hst_rdata;
  logic        ctl_rst_n, ctl_addr_sel, ctl_rd, ctl_strobe;
  logic [15:0] ctl_wdata;
  logic [15:0] ctl_rdata = 16'h0000;
  logic        ctl_ack = 1'b0;
  logic        ctl_irq = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bb_bridge #(.TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_we(hst_we),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ctl_rst_n(ctl_rst_n),
    .ctl_addr_sel(ctl_addr_sel), .ctl_rd(ctl_rd), .ctl_strobe(ctl_strobe),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_ack(ctl_ack),
    .ctl_irq(ctl_irq)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] wword;
    logic [15:0] rword;
    logic [7:0]  delay;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h0B, 16'h1234, 16'hA55A, 8'd0},
    '{8'h08, 16'hBEEF, 16'h0F0F, 8'd3},
    '{8'h0A, 16'h00FF, 16'hC3E1, 8'd7},
    '{8'h09, 16'h8001, 16'h7777, 8'd1},
    '{8'h0B, 16'h5A00, 16'h0102, 8'd12},
    '{8'h0A, 16'hFFFF, 16'hFE80, 8'd2},
    '{8'h08, 16'h4321, 16'h9999, 8'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hst_sel = sel; hst_wdata = d; hst_we = 1'b1;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [7:0] d);
    hst_sel = sel;
    #0.5;
    d = hst_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] exp_rd;
    int          n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset view
    hread(2'd2, b); chk("R1 ctrl/status", b, 8'h10);
    chk("R1 ctl_rst_n", ctl_rst_n, 1'b0);
    chk("R1 strobe", ctl_strobe, 1'b0);
    hread(2'd0, b); chk("R1 rd lo", b, 8'h00);
    hread(2'd1, b); chk("R1 rd hi", b, 8'h00);
    exp_rd = 16'h0000;

    // Table walk: R6, R7, R8, R2
    for (int i = 0; i < NV; i++) begin
      hwrite(2'd2, VECS[i].ctrl);
      hwrite(2'd0, VECS[i].wword[7:0]);
      hwrite(2'd1, VECS[i].wword[15:8]);
      hread(2'd0, b); chk("R2 rd lo not write", b, exp_rd[7:0]);
      hwrite(2'd3, 8'h80 ^ 8'(i));
      hread(2'd2, b); chk("R6 busy bit", b[5], 1'b1);
      chk("R6 addr_sel", ctl_addr_sel, VECS[i].ctrl[0]);
      chk("R6 rd", ctl_rd, VECS[i].ctrl[1]);
      chk("R6 wdata", ctl_wdata, VECS[i].wword);
      chk("R4 ctl_rst_n", ctl_rst_n, VECS[i].ctrl[3]);
      for (int d = 0; d < int'(VECS[i].delay); d++) begin
        @(negedge clk);
        chk("R7 strobe held", ctl_strobe, 1'b1);
      end
      ctl_rdata = VECS[i].rword; ctl_ack = 1'b1;
      @(negedge clk);
      ctl_ack = 1'b0; ctl_rdata = 16'hDEAD;
      chk("R7 strobe off", ctl_strobe, 1'b0);
      hread(2'd2, b); chk("R7 busy clear", b[5], 1'b0);
      if (VECS[i].ctrl[1]) exp_rd = VECS[i].rword;
      hread(2'd0, b); chk(VECS[i].ctrl[1] ? "R7 rd lo" : "R8 rd lo kept", b, exp_rd[7:0]);
      hread(2'd1, b); chk(VECS[i].ctrl[1] ? "R7 rd hi" : "R8 rd hi kept", b, exp_rd[15:8]);
    end

    // R3 status bits ignore writes, R5 irq polarity, R2 offset 3
    hwrite(2'd2, 8'hFF);
    hread(2'd2, b); chk("R3 ctrl readback", b, 8'h1B);
    ctl_irq = 1'b1;
    hread(2'd2, b); chk("R5 irq pending", b, 8'h0B);
    ctl_irq = 1'b0;
    hread(2'd3, b); chk("R2 cmd reads 0", b, 8'h00);
    hwrite(2'd2, 8'h30);
    hread(2'd2, b); chk("R3 status not writable", b, 8'h10);
    chk("R4 reset asserted", ctl_rst_n, 1'b0);

    // R10 timeout on a read transfer, with R9/R11 command and ctrl change mid-way
    hwrite(2'd2, 8'h0B);
    hwrite(2'd3, 8'h00);
    n = 0;
    while (ctl_strobe && n < 4 * int'(TMO)) begin
      n++;
      if (n == 4) begin
        hst_sel = 2'd2; hst_wdata = 8'h08; hst_we = 1'b1;
      end else if (n == 6) begin
        hst_sel = 2'd3; hst_wdata = 8'h80; hst_we = 1'b1;
      end else begin
        hst_we = 1'b0;
      end
      if (n == 8) begin
        chk("R11 addr_sel kept", ctl_addr_sel, 1'b1);
        chk("R9 rd kept", ctl_rd, 1'b1);
      end
      @(negedge clk);
    end
    hst_we = 1'b0;
    chk("R10 R9 strobe length", n, TMO);
    hread(2'd2, b); chk("R10 busy clear", b, 8'h18);
    hread(2'd0, b); chk("R10 rd lo kept", b, exp_rd[7:0]);
    hread(2'd1, b); chk("R10 rd hi kept", b, exp_rd[15:8]);

    // R6 new transfer after timeout uses updated ctrl (write, data port)
    hwrite(2'd3, 8'h55);
    chk("R6 restart rd", ctl_rd, 1'b0);
    chk("R6 restart addr_sel", ctl_addr_sel, 1'b0);
    ctl_ack = 1'b1;
    @(negedge clk);
    ctl_ack = 1'b0;
    chk("R7 restart end", ctl_strobe, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule